// File: doc/BRIEF.md
# Sector Header Match and Read Checker

This block sits behind the clock-recovery stage of a disk read channel and takes the recovered serial bit stream one qualified bit at a time. It hunts for the one-bit mark that closes the run of zeros in front of each sector. It then captures the 37-bit sector header and checks the header's odd parity. Three address fields in the header are compared with target values that the surrounding controller holds.

When every field agrees, the header is accepted. The block then steps over the indeterminate gap and hunts for the data sync mark. It deserializes the data words, checking the odd parity of each word, and compares the trailing longitudinal check word with odd parity accumulated per bit position. Each data word is presented on a valid strobe together with its own parity flag. A header that disagrees with the targets, or that fails its parity, sends the block back to preamble hunting. A count of sector pulses that pass without an accepted header raises a header-not-found flag.

Top module: `sector_hdr_reader`

## Requirements
- R1: A 1 bit is taken as the header start mark only when at least MIN_ZEROS (16) consecutive zeros came before it while hunting. A 1 that follows a shorter run is ignored, and the zero count starts again.
- R2: The header bits are numbered 0 to 36 in arrival order. Bits 18..25 hold the cylinder, bits 26..30 the head and bits 32..35 the sector, each with the lowest bit number as MSB. Bit 36 is the header parity bit. When all three fields equal tgtCyl, tgtHead and tgtSector, hdrMatch pulses for one cycle after the last header bit.
- R3: A header whose 37 bits do not hold an odd number of ones, or that has any field unequal to its target, produces no hdrMatch and no data output. The block hunts again and accepts the next valid header.
- R4: The GAP_BITS bits that follow an accepted header are ignored whatever they contain, including a zero run followed by a 1.
- R5: The data field starts after a 1 bit that ends a run of at least MIN_ZEROS zeros counted from the end of the gap. A shorter run is ignored.
- R6: DATA_WORDS words of 36 bits, each sent MSB first and followed by its parity bit, appear in order on wordData. wordValid pulses once per word, and words appear only after an accepted header.
- R7: wordParErr pulses with a word exactly when that word's 36 bits plus its parity bit hold an even number of ones.
- R8: After the last data word, a 36-bit check word and its parity bit are read. lprDone pulses once. lprErr pulses with it when the check word differs from the inverted XOR of all data words, or when its 37 bits hold an even number of ones.
- R9: With missLimit nonzero, hdrNotFound goes high on the missLimit-th sectorPulse since reset or since the last accepted header. It stays high until a header is accepted. With missLimit zero the flag never rises.
- R10: After reset, hdrMatch, wordValid, wordParErr, lprDone, lprErr and hdrNotFound are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | bitIn carries a recovered bit this cycle |
| bitIn | input | 1 | Recovered serial data bit |
| sectorPulse | input | 1 | One-cycle pulse per sector passing under the head |
| tgtCyl | input | 8 | Target cylinder |
| tgtHead | input | 5 | Target head |
| tgtSector | input | 4 | Target sector |
| missLimit | input | MISS_W | Sector pulses allowed before header-not-found, 0 disables |
| hdrMatch | output | 1 | Pulse: header accepted |
| wordValid | output | 1 | Pulse: wordData holds a data word |
| wordData | output | 36 | Deserialized data word |
| wordParErr | output | 1 | Pulse with wordValid: word parity failed |
| lprDone | output | 1 | Pulse: longitudinal check word read |
| lprErr | output | 1 | Pulse with lprDone: longitudinal check failed |
| hdrNotFound | output | 1 | Level: too many sector pulses without a match |

## Verification
The bound checker watches several properties on every cycle. A header is never accepted while a sector is still being read, and data words appear only inside an accepted sector. Each check-word strobe arrives after exactly DATA_WORDS words. The error pulses come only with their own strobes, and header-not-found rises only on a sector pulse and is never high beside an accepted header. Other behaviours can only be shown by the bench's scenarios: the values of the words, which word carries a parity error, rejection by field or by parity, the rule that a short zero run is not a sync mark, and ignoring a misleading gap pattern.

// File: rtl/shr_pkg.sv
package shr_pkg;

  // one serial word: 36 data bits then a parity bit
  localparam int WORD_BITS = 36;
  localparam int FRAME_BITS = WORD_BITS + 1;

  // header field positions inside the shift register after a full frame
  // (arrival bit k lands at index FRAME_BITS-1-k)
  localparam int CYL_W = 8;
  localparam int HEAD_W = 5;
  localparam int SEC_W = 4;
  localparam int CYL_LSB = 11;
  localparam int HEAD_LSB = 6;
  localparam int SEC_LSB = 1;

  typedef enum logic [2:0] {
    S_HUNT_PRE,
    S_HDR,
    S_GAP,
    S_HUNT_SYNC,
    S_DATA,
    S_LPR
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hunt;
    logic clrRun;
    logic shiftEn;
    logic clrAcc;
    logic wordLast;
    logic lprLast;
  } dpStrobe_t;

endpackage

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
#(
  parameter int MIN_ZEROS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bitValid,
  input  logic                 bitIn,
  input  dpStrobe_t            strobe,
  input  logic [CYL_W-1:0]     tgtCyl,
  input  logic [HEAD_W-1:0]    tgtHead,
  input  logic [SEC_W-1:0]     tgtSector,
  output logic                 syncSeen,
  output logic                 hdrOk,
  output logic                 wordValid,
  output logic [WORD_BITS-1:0] wordData,
  output logic                 wordParErr,
  output logic                 lprDone,
  output logic                 lprErr
);

  localparam int ZR_W = $clog2(MIN_ZEROS + 1);
  localparam logic [ZR_W-1:0] ZR_MAX = ZR_W'(MIN_ZEROS);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] shiftNext;
  logic [ZR_W-1:0]       zeroRun;
  logic [WORD_BITS-1:0]  lprAcc;
  logic                  frameOdd;
  logic                  fieldsEq;
  logic                  lprBad;

  assign shiftNext = {shiftReg[FRAME_BITS-2:0], bitIn};
  assign frameOdd  = ^shiftNext;

  // header compare works on the frame including the bit arriving now
  assign fieldsEq = (shiftNext[CYL_LSB+CYL_W-1:CYL_LSB] == tgtCyl) &&
                    (shiftNext[HEAD_LSB+HEAD_W-1:HEAD_LSB] == tgtHead) &&
                    (shiftNext[SEC_LSB+SEC_W-1:SEC_LSB] == tgtSector);
  assign hdrOk = fieldsEq && frameOdd;

  // expected check word is the inverted column XOR (odd per column)
  assign lprBad = (shiftNext[FRAME_BITS-1:1] != ~lprAcc) || !frameOdd;

  assign syncSeen = strobe.hunt && bitValid && bitIn && (zeroRun == ZR_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zeroRun <= '0;
    end else if (strobe.clrRun) begin
      zeroRun <= '0;
    end else if (bitValid && strobe.hunt) begin
      if (bitIn) begin
        zeroRun <= '0;
      end else if (zeroRun != ZR_MAX) begin
        zeroRun <= zeroRun + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lprAcc <= '0;
    end else if (strobe.clrAcc) begin
      lprAcc <= '0;
    end else if (strobe.wordLast) begin
      lprAcc <= lprAcc ^ shiftNext[FRAME_BITS-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordValid  <= 1'b0;
      wordData   <= '0;
      wordParErr <= 1'b0;
      lprDone    <= 1'b0;
      lprErr     <= 1'b0;
    end else begin
      wordValid  <= strobe.wordLast;
      wordParErr <= strobe.wordLast && !frameOdd;
      lprDone    <= strobe.lprLast;
      lprErr     <= strobe.lprLast && lprBad;
      if (strobe.wordLast) begin
        wordData <= shiftNext[FRAME_BITS-1:1];
      end
    end
  end

endmodule

// File: rtl/shr_control.sv
module shr_control
  import shr_pkg::*;
#(
  parameter int DATA_WORDS = 128,
  parameter int GAP_BITS   = 24,
  parameter int MISS_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitValid,
  input  logic              sectorPulse,
  input  logic [MISS_W-1:0] missLimit,
  input  logic              syncSeen,
  input  logic              hdrOk,
  output dpStrobe_t         strobe,
  output logic              hdrMatch,
  output logic              hdrNotFound
);

  localparam int MAXB = (GAP_BITS > FRAME_BITS) ? GAP_BITS : FRAME_BITS;
  localparam int CNT_W = $clog2(MAXB);
  localparam int WC_W = $clog2(DATA_WORDS);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_BITS - 1);
  localparam logic [WC_W-1:0] WORDS_LAST = WC_W'(DATA_WORDS - 1);

  rdState_e          state, stateN;
  logic [CNT_W-1:0]  bitCnt, bitCntN;
  logic [WC_W-1:0]   wordCnt, wordCntN;
  logic              accept;
  logic [MISS_W-1:0] missCnt;
  logic [MISS_W-1:0] missInc;

  assign missInc = missCnt + 1'b1;

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    wordCntN = wordCnt;
    strobe   = '0;
    accept   = 1'b0;
    case (state)
      S_HUNT_PRE: begin
        strobe.hunt = 1'b1;
        if (syncSeen) begin
          stateN  = S_HDR;
          bitCntN = '0;
        end
      end
      S_HDR: begin
        strobe.shiftEn = bitValid;
        if (bitValid) begin
          if (bitCnt == FRAME_LAST) begin
            bitCntN = '0;
            if (hdrOk) begin
              accept = 1'b1;
              stateN = S_GAP;
            end else begin
              strobe.clrRun = 1'b1;
              stateN = S_HUNT_PRE;
            end
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
      end
      S_GAP: begin
        if (bitValid) begin
          if (bitCnt == GAP_LAST) begin
            bitCntN       = '0;
            strobe.clrRun = 1'b1;
            stateN        = S_HUNT_SYNC;
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
      end
      S_HUNT_SYNC: begin
        strobe.hunt = 1'b1;
        if (syncSeen) begin
          strobe.clrAcc = 1'b1;
          bitCntN  = '0;
          wordCntN = '0;
          stateN   = S_DATA;
        end
      end
      S_DATA: begin
        strobe.shiftEn = bitValid;
        if (bitValid) begin
          if (bitCnt == FRAME_LAST) begin
            strobe.wordLast = 1'b1;
            bitCntN = '0;
            if (wordCnt == WORDS_LAST) begin
              stateN = S_LPR;
            end else begin
              wordCntN = wordCnt + 1'b1;
            end
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
      end
      S_LPR: begin
        strobe.shiftEn = bitValid;
        if (bitValid) begin
          if (bitCnt == FRAME_LAST) begin
            strobe.lprLast = 1'b1;
            strobe.clrRun  = 1'b1;
            bitCntN = '0;
            stateN  = S_HUNT_PRE;
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
      end
      default: stateN = S_HUNT_PRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_HUNT_PRE;
      bitCnt   <= '0;
      wordCnt  <= '0;
      hdrMatch <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      wordCnt  <= wordCntN;
      hdrMatch <= accept;
    end
  end

  // sector pulses without an accepted header
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      missCnt     <= '0;
      hdrNotFound <= 1'b0;
    end else if (accept) begin
      missCnt     <= '0;
      hdrNotFound <= 1'b0;
    end else if (sectorPulse && !hdrNotFound) begin
      missCnt <= missInc;
      if ((missLimit != '0) && (missInc == missLimit)) begin
        hdrNotFound <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sector_hdr_reader.sv
module sector_hdr_reader
  import shr_pkg::*;
#(
  parameter int DATA_WORDS = 128,
  parameter int MIN_ZEROS  = 16,
  parameter int GAP_BITS   = 24,
  parameter int MISS_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bitValid,
  input  logic                 bitIn,
  input  logic                 sectorPulse,
  input  logic [7:0]           tgtCyl,
  input  logic [4:0]           tgtHead,
  input  logic [3:0]           tgtSector,
  input  logic [MISS_W-1:0]    missLimit,
  output logic                 hdrMatch,
  output logic                 wordValid,
  output logic [35:0]          wordData,
  output logic                 wordParErr,
  output logic                 lprDone,
  output logic                 lprErr,
  output logic                 hdrNotFound
);

  dpStrobe_t strobe;
  logic      syncSeen;
  logic      hdrOk;

  shr_control #(
    .DATA_WORDS(DATA_WORDS),
    .GAP_BITS  (GAP_BITS),
    .MISS_W    (MISS_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bitValid   (bitValid),
    .sectorPulse(sectorPulse),
    .missLimit  (missLimit),
    .syncSeen   (syncSeen),
    .hdrOk      (hdrOk),
    .strobe     (strobe),
    .hdrMatch   (hdrMatch),
    .hdrNotFound(hdrNotFound)
  );

  shr_datapath #(
    .MIN_ZEROS(MIN_ZEROS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitValid  (bitValid),
    .bitIn     (bitIn),
    .strobe    (strobe),
    .tgtCyl    (tgtCyl),
    .tgtHead   (tgtHead),
    .tgtSector (tgtSector),
    .syncSeen  (syncSeen),
    .hdrOk     (hdrOk),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordParErr(wordParErr),
    .lprDone   (lprDone),
    .lprErr    (lprErr)
  );

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int DATA_WORDS = 128
) (
  input logic clk,
  input logic rst_n,
  input logic sectorPulse,
  input logic hdrMatch,
  input logic wordValid,
  input logic wordParErr,
  input logic lprDone,
  input logic lprErr,
  input logic hdrNotFound
);

  logic inSector;
  int   wordsSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inSector  <= 1'b0;
      wordsSeen <= 0;
    end else begin
      if (hdrMatch) begin
        inSector  <= 1'b1;
        wordsSeen <= 0;
      end else if (lprDone) begin
        inSector <= 1'b0;
      end else if (wordValid) begin
        wordsSeen <= wordsSeen + 1;
      end
    end
  end

  // R2: a header is accepted only between sectors
  p_match_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdrMatch |-> (!inSector && !wordValid && !lprDone));

  // R6: data words only inside an accepted sector
  p_word_in_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |-> inSector);

  // R7: parity flag only travels with a word
  p_parerr_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wordParErr |-> wordValid);

  // R8: check word follows exactly the full word count
  p_lpr_after_words_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lprDone |-> (inSector && wordsSeen == DATA_WORDS));

  // R8: check error only with its strobe
  p_lprerr_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lprErr |-> lprDone);

  // R9: the flag rises only on a sector pulse
  p_hnf_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrNotFound) |-> $past(sectorPulse));

  // R9: an accepted header clears the flag
  p_match_clears_hnf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdrMatch |-> !hdrNotFound);

endmodule

bind sector_hdr_reader shr_checker #(
  .DATA_WORDS(DATA_WORDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sectorPulse(sectorPulse),
  .hdrMatch   (hdrMatch),
  .wordValid  (wordValid),
  .wordParErr (wordParErr),
  .lprDone    (lprDone),
  .lprErr     (lprErr),
  .hdrNotFound(hdrNotFound)
);

// File: tb/sim_sector_hdr_reader.sv
module sim_sector_hdr_reader;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_WORDS = 128;
  localparam int MIN_ZEROS = 16;
  localparam int GAP_BITS = 24;
  localparam int MISS_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bitValid = 1'b0;
  logic              bitIn = 1'b0;
  logic              sectorPulse = 1'b0;
  logic [7:0]        tgtCyl = '0;
  logic [4:0]        tgtHead = '0;
  logic [3:0]        tgtSector = '0;
  logic [MISS_W-1:0] missLimit = '0;
  logic              hdrMatch, wordValid, wordParErr, lprDone, lprErr, hdrNotFound;
  logic [35:0]       wordData;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_hdr_reader #(
    .DATA_WORDS(DATA_WORDS), .MIN_ZEROS(MIN_ZEROS),
    .GAP_BITS(GAP_BITS), .MISS_W(MISS_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .sectorPulse(sectorPulse), .tgtCyl(tgtCyl), .tgtHead(tgtHead),
    .tgtSector(tgtSector), .missLimit(missLimit), .hdrMatch(hdrMatch),
    .wordValid(wordValid), .wordData(wordData), .wordParErr(wordParErr),
    .lprDone(lprDone), .lprErr(lprErr), .hdrNotFound(hdrNotFound)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [35:0] expWord[DATA_WORDS];
  bit          expPe[DATA_WORDS];
  int          wIdx = 0;
  int          matchCnt = 0;
  int          lprCnt = 0;
  bit          lastLprErr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hdrMatch) begin
        matchCnt++;
        wIdx = 0;
      end
      if (wordValid) begin
        if (wIdx < DATA_WORDS) begin
          chk(wordData == expWord[wIdx], "R6", "word value", wordData, expWord[wIdx]);
          chk(wordParErr == expPe[wIdx], "R7", "word parity flag", wordParErr, expPe[wIdx]);
        end else begin
          chk(1'b0, "R6", "word beyond sector", wIdx, DATA_WORDS);
        end
        wIdx++;
      end
      if (lprDone) begin
        lprCnt++;
        lastLprErr = lprErr;
      end
    end
  end

  task automatic sendBit(input logic b);
    if ($urandom_range(0, 7) == 0) @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    bitIn = 1'b0;
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic sendFrame(input logic [36:0] v);
    for (int i = 36; i >= 0; i--) sendBit(v[i]);
  endtask

  // header per R2: arrival bit k at index 36-k
  function automatic logic [36:0] mkHdr(input logic [7:0] c, input logic [4:0] h,
                                        input logic [3:0] s, input bit badPar);
    logic [36:0] v;
    v = '0;
    v[18:11] = c;
    v[10:6] = h;
    v[4:1] = s;
    v[0] = ~(^v[36:1]) ^ badPar;
    return v;
  endfunction

  // gapMode: 0 random with ones, 1 misleading zero run then 1
  task automatic sendSector(input logic [7:0] c, input logic [4:0] h, input logic [3:0] s,
                            input bit badHdrPar, input int preZeros, input int gapMode,
                            input bit splitSync, input int badWord, input bit badLpr);
    logic [35:0] acc;
    logic [35:0] lw;
    logic [36:0] g;
    acc = '0;
    for (int i = 0; i < DATA_WORDS; i++) begin
      expWord[i] = {$urandom_range(0, 15), $urandom};
      expPe[i] = (i == badWord);
      acc ^= expWord[i];
    end
    lw = ~acc;
    if (badLpr) lw[7] = ~lw[7];
    sendZeros(preZeros);
    sendBit(1'b1);
    sendFrame(mkHdr(c, h, s, badHdrPar));
    for (int i = 0; i < GAP_BITS; i++) begin
      if (gapMode == 1) sendBit((i == 0) || (i == 19) || (i > 19));
      else sendBit((i % 3 == 0) ? 1'b1 : 1'($urandom));
    end
    if (splitSync) begin
      sendZeros(5);
      sendBit(1'b1);
    end
    sendZeros(20);
    sendBit(1'b1);
    for (int i = 0; i < DATA_WORDS; i++)
      sendFrame({expWord[i], ~(^expWord[i]) ^ expPe[i]});
    sendFrame({lw, ~(^lw)});
    g = {$urandom, $urandom} | 37'h0842108421;
    sendFrame(g);
    repeat (3) @(negedge clk);
  endtask

  task automatic expectSector(input string req, input int m0, input int l0,
                              input int expM, input int expL, input bit expErr);
    chk(matchCnt - m0 == expM, req, "header matches", matchCnt - m0, expM);
    chk(lprCnt - l0 == expL, req, "check word strobes", lprCnt - l0, expL);
    if (expL > 0) chk(lastLprErr == expErr, req, "check word error", lastLprErr, expErr);
    if (expL > 0) chk(wIdx == DATA_WORDS, req, "word count", wIdx, DATA_WORDS);
  endtask

  task automatic pulseSector();
    sectorPulse = 1'b1;
    @(negedge clk);
    sectorPulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int m0, l0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({hdrMatch, wordValid, wordParErr, lprDone, lprErr, hdrNotFound} == 6'b0,
        "R10", "outputs in reset", {hdrMatch, wordValid, wordParErr, lprDone, lprErr, hdrNotFound}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hdrMatch, wordValid, lprDone, hdrNotFound} == 4'b0, "R10", "outputs after reset",
        {hdrMatch, wordValid, lprDone, hdrNotFound}, 0);

    tgtCyl = 8'hA5; tgtHead = 5'h13; tgtSector = 4'h7;

    // R2 R6 R8 plain good sector
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 0, 30, 0, 0, -1, 0);
    expectSector("R2", m0, l0, 1, 1, 0);

    // R3 bad header parity, then R4 misleading gap on a good sector
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 1, 30, 0, 0, -1, 0);
    expectSector("R3", m0, l0, 0, 0, 0);
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 0, 30, 1, 0, -1, 0);
    expectSector("R4", m0, l0, 1, 1, 0);

    // R3 each field mismatching
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA4, 5'h13, 4'h7, 0, 30, 0, 0, -1, 0);
    sendSector(8'hA5, 5'h03, 4'h7, 0, 30, 0, 0, -1, 0);
    sendSector(8'hA5, 5'h13, 4'h6, 0, 30, 0, 0, -1, 0);
    expectSector("R3", m0, l0, 0, 0, 0);

    // R1 short preamble before a header is ignored, long one accepted
    m0 = matchCnt; l0 = lprCnt;
    sendZeros(10);
    sendBit(1'b1);
    sendFrame(mkHdr(8'hA5, 5'h13, 4'h7, 0));
    sendSector(8'hA5, 5'h13, 4'h7, 0, 60, 0, 0, -1, 0);
    expectSector("R1", m0, l0, 1, 1, 0);

    // R5 short sync run ignored; R7 parity error on word 5 only
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 0, 30, 0, 1, 5, 0);
    expectSector("R5", m0, l0, 1, 1, 0);

    // R8 corrupted check word
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 0, 30, 0, 0, -1, 1);
    expectSector("R8", m0, l0, 1, 1, 1);

    // R9 header-not-found
    missLimit = 4'd3;
    pulseSector();
    pulseSector();
    chk(hdrNotFound == 1'b0, "R9", "flag before limit", hdrNotFound, 0);
    pulseSector();
    chk(hdrNotFound == 1'b1, "R9", "flag at limit", hdrNotFound, 1);
    pulseSector();
    chk(hdrNotFound == 1'b1, "R9", "flag held", hdrNotFound, 1);
    m0 = matchCnt; l0 = lprCnt;
    sendSector(8'hA5, 5'h13, 4'h7, 0, 30, 0, 0, -1, 0);
    expectSector("R9", m0, l0, 1, 1, 0);
    chk(hdrNotFound == 1'b0, "R9", "flag cleared by match", hdrNotFound, 0);
    missLimit = 4'd0;
    repeat (6) pulseSector();
    chk(hdrNotFound == 1'b0, "R9", "limit zero disables", hdrNotFound, 0);

    // R2 R3 constrained random targets
    for (int k = 0; k < 3; k++) begin
      logic [7:0] c;
      logic [4:0] h;
      logic [3:0] s;
      bit hit;
      int f;
      tgtCyl = 8'($urandom); tgtHead = 5'($urandom); tgtSector = 4'($urandom);
      c = tgtCyl; h = tgtHead; s = tgtSector;
      hit = 1'($urandom);
      f = $urandom_range(0, 2);
      if (!hit) begin
        if (f == 0) c[$urandom_range(0, 7)] ^= 1'b1;
        else if (f == 1) h[$urandom_range(0, 4)] ^= 1'b1;
        else s[$urandom_range(0, 3)] ^= 1'b1;
      end
      m0 = matchCnt; l0 = lprCnt;
      sendSector(c, h, s, 0, 30, 0, 0, -1, 0);
      expectSector(hit ? "R2" : "R3", m0, l0, int'(hit), int'(hit), 0);
    end

    summary();
  end

endmodule